// File: doc/BRIEF.md
# Prescaled Baud Rate Generator

This block produces the per-bit timing tick for one serial channel, running from the system clock. A power-of-two prescaler, chosen by a clock-select setting, drives an 8-bit reload counter chosen by a bit-count setting. The counter's wrap is halved once more, so one `tick` pulse marks each serial bit. The pulse period is 2^k × N × 2 system clocks.

The two settings are loaded through write strobes. Any write, or a low channel enable, returns every divider stage to its starting point. The next bit period therefore begins at a known cycle. The block also exports the prescaled-clock pulse `preTick`, which the channel uses to time its settling wait after a mode change. Clock-select values outside the legal window are pulled into it. The lower edge of that window is the smallest k that keeps CLK_HZ / 2^k at or below LIMIT_HZ. Count values below the floor are raised to it.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rstN` is low, `tick` and `preTick` are low. After reset the clock-select value is the legal minimum (1 for the default 50 MHz / 25 MHz parameters) and the count value is 8, so with `clkEn` high the first `tick` falls in cycle 2^1·8·2−1 = 31 after reset release.
- R2: With effective select k and effective count N, `tick` is high for exactly one cycle, first in cycle P−1 after a restart, and then every P cycles, where P = 2^k·N·2.
- R3: `preTick` pulses once every 2^k cycles, first in cycle 2^k−1 after a restart. There are exactly 2·N `preTick` pulses in the cycles 0..P−1, and every `tick` coincides with a `preTick`.
- R4: A written clock-select value above 11 takes effect as 11.
- R5: A written clock-select value below the legal minimum takes effect as the minimum (select 0 acts as 1 with default parameters).
- R6: A written count value below 8 takes effect as 8. Values 8 to 255 are used as written.
- R7: A write strobe on either setting restarts all divider stages, so the cycle after the write edge is cycle 0 of R2/R3. A setting that is not written keeps its previous value.
- R8: While `clkEn` is low, `tick` and `preTick` stay low and the dividers are held at their start. Writes are still accepted. Raising `clkEn` restarts the dividers exactly as a write does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Channel clock enable |
| selWrite | input | 1 | Load strobe for the clock-select setting |
| selData | input | 4 | Clock-select value k |
| cntWrite | input | 1 | Load strobe for the count setting |
| cntData | input | 8 | Count value N |
| preTick | output | 1 | One-cycle pulse per prescaled clock period |
| tick | output | 1 | One-cycle pulse per serial bit |

## Verification
The hardest case to reach is a restart that lands part-way through a bit period. The prescaler, the counter and the halving stage must all drop their partial counts at once. Otherwise the next `tick` shows up early by an amount that depends on where each stage was. The random part of the bench writes one configuration and lets it run a random number of cycles. It then rewrites mid-count and measures the first `tick` and `preTick` positions from that second write. A directed run at select 15 and count 8 reaches the largest period the cycle budget allows, and also covers the upper clamp.

// File: rtl/bt_pkg.sv
package bt_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic run;
  } btStrobe_t;

  // smallest select that brings clkHz down to limHz, capped at selMax
  function automatic int minSel(longint clkHz, longint limHz, int selMax);
    longint f;
    int k;
    f = clkHz;
    k = 0;
    for (int i = 0; i < selMax; i++) begin
      if (f > limHz) begin
        f = f >> 1;
        k = k + 1;
      end
    end
    return k;
  endfunction

endpackage

// File: rtl/bt_ctrl.sv
module bt_ctrl
  import bt_pkg::*;
#(
  parameter int SEL_W     = 4,
  parameter int CNT_W     = 8,
  parameter int SEL_MAX   = 11,
  parameter int SEL_MIN   = 1,
  parameter int CNT_FLOOR = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             selWrite,
  input  logic [SEL_W-1:0] selData,
  input  logic             cntWrite,
  input  logic [CNT_W-1:0] cntData,
  output btStrobe_t        strobe,
  output logic [SEL_W-1:0] cfgSel,
  output logic [CNT_W-1:0] cfgCnt
);

  localparam logic [SEL_W-1:0] SelHi  = SEL_W'(SEL_MAX);
  localparam logic [SEL_W-1:0] SelLo  = SEL_W'(SEL_MIN);
  localparam logic [CNT_W-1:0] CntLo  = CNT_W'(CNT_FLOOR);

  logic [SEL_W-1:0] selClamp;
  logic [CNT_W-1:0] cntClamp;

  // pull written values into the legal window
  always_comb begin
    if (selData > SelHi)      selClamp = SelHi;
    else if (selData < SelLo) selClamp = SelLo;
    else                      selClamp = selData;
    cntClamp = (cntData < CntLo) ? CntLo : cntData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgSel <= SelLo;
      cfgCnt <= CntLo;
    end else begin
      if (selWrite) cfgSel <= selClamp;
      if (cntWrite) cfgCnt <= cntClamp;
    end
  end

  // any write or a disabled channel returns the dividers to their start
  always_comb begin
    strobe.restart = selWrite | cntWrite | ~clkEn;
    strobe.run     = clkEn & ~strobe.restart;
  end

endmodule

// File: rtl/bt_dp.sv
module bt_dp
  import bt_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int CNT_W = 8,
  parameter int PRE_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  btStrobe_t        strobe,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic [CNT_W-1:0] cfgCnt,
  output logic             preTick,
  output logic             tick
);

  logic [PRE_W:0]   preSpan;
  logic [PRE_W-1:0] preLimit;
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] divCnt;
  logic             divHit;
  logic             halfPhase;
  logic             preHit;

  // terminal count of the power-of-two prescaler: 2^k - 1
  always_comb begin
    preSpan  = (PRE_W+1)'(1) << cfgSel;
    preLimit = preSpan[PRE_W-1:0] - PRE_W'(1);
    preHit   = strobe.run && (preCnt == preLimit);
    divHit   = preHit && (divCnt == cfgCnt - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) begin
      preCnt <= '0;
    end else if (preHit) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) begin
      divCnt <= '0;
    end else if (preHit) begin
      divCnt <= divHit ? '0 : divCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) begin
      halfPhase <= 1'b0;
    end else if (divHit) begin
      halfPhase <= ~halfPhase;
    end
  end

  assign preTick = preHit;
  assign tick    = divHit & halfPhase;

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import bt_pkg::*;
#(
  parameter longint CLK_HZ    = 50_000_000,
  parameter longint LIMIT_HZ  = 25_000_000,
  parameter int     SEL_W     = 4,
  parameter int     CNT_W     = 8,
  parameter int     SEL_MAX   = 11,
  parameter int     CNT_FLOOR = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             selWrite,
  input  logic [SEL_W-1:0] selData,
  input  logic             cntWrite,
  input  logic [CNT_W-1:0] cntData,
  output logic             preTick,
  output logic             tick
);

  localparam int SEL_MIN = minSel(CLK_HZ, LIMIT_HZ, SEL_MAX);
  localparam int PRE_W   = (SEL_MAX > 0) ? SEL_MAX : 1;

  btStrobe_t        strobe;
  logic [SEL_W-1:0] cfgSel;
  logic [CNT_W-1:0] cfgCnt;

  bt_ctrl #(
    .SEL_W(SEL_W), .CNT_W(CNT_W), .SEL_MAX(SEL_MAX),
    .SEL_MIN(SEL_MIN), .CNT_FLOOR(CNT_FLOOR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn),
    .selWrite(selWrite), .selData(selData),
    .cntWrite(cntWrite), .cntData(cntData),
    .strobe(strobe), .cfgSel(cfgSel), .cfgCnt(cfgCnt)
  );

  bt_dp #(
    .SEL_W(SEL_W), .CNT_W(CNT_W), .PRE_W(PRE_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgSel(cfgSel), .cfgCnt(cfgCnt),
    .preTick(preTick), .tick(tick)
  );

endmodule

// File: rtl/bt_checker.sv
module bt_checker #(
  parameter int SEL_W   = 4,
  parameter int SEL_MIN = 1,
  parameter int SEL_MAX = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkEn,
  input logic             selWrite,
  input logic             cntWrite,
  input logic             preTick,
  input logic             tick,
  input logic [SEL_W-1:0] cfgSel
);

  // R2: tick lasts one cycle
  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  // R3: each tick sits on a prescaled-clock pulse
  p_tick_on_pre_r3: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> preTick);

  // R8: a disabled channel emits nothing
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |-> (!tick && !preTick));

  // R7: a write restarts, so no tick can follow in the next cycle
  p_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (selWrite || cntWrite) |=> !tick);

  // R4/R5: the stored select always lies in the legal window
  p_sel_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSel <= SEL_W'(SEL_MAX)) && (cfgSel >= SEL_W'(SEL_MIN)));

endmodule

bind baud_tick_gen bt_checker #(
  .SEL_W(SEL_W), .SEL_MIN(SEL_MIN), .SEL_MAX(SEL_MAX)
) uChk (
  .clk(clk), .rstN(rstN), .clkEn(clkEn),
  .selWrite(selWrite), .cntWrite(cntWrite),
  .preTick(preTick), .tick(tick), .cfgSel(cfgSel)
);

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkEn = 1'b0;
  logic       selWrite = 1'b0;
  logic [3:0] selData = '0;
  logic       cntWrite = 1'b0;
  logic [7:0] cntData = '0;
  logic       preTick;
  logic       tick;

  int checks = 0;
  int fails = 0;
  int curSel = 1;
  int curCnt = 8;
  bit done = 1'b0;

  always #10 clk = ~clk;

  baud_tick_gen u0 (
    .clk(clk), .rstN(rstN), .clkEn(clkEn),
    .selWrite(selWrite), .selData(selData),
    .cntWrite(cntWrite), .cntData(cntData),
    .preTick(preTick), .tick(tick)
  );

  function automatic int effSel(int k);
    if (k > 11) return 11;
    if (k < 1) return 1;
    return k;
  endfunction

  function automatic int effCnt(int n);
    return (n < 8) ? 8 : n;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // samples cycles 0..2P-1 after a restart, 5 ns after each falling edge
  task automatic observe(string req);
    int k = effSel(curSel);
    int n = effCnt(curCnt);
    int p = (1 << k) * n * 2;
    int firstTick = -1;
    int secondTick = -1;
    int firstPre = -1;
    int preCount = 0;
    int ticksSeen = 0;
    for (int idx = 0; idx < 2 * p; idx++) begin
      #5;
      if (preTick) begin
        if (firstPre < 0) firstPre = idx;
        if (idx < p) preCount++;
      end
      if (tick) begin
        ticksSeen++;
        if (firstTick < 0) firstTick = idx;
        else if (secondTick < 0) secondTick = idx;
      end
      @(negedge clk);
    end
    check(firstTick == p - 1, {req, " R2 first tick"}, firstTick, p - 1);
    check(secondTick - firstTick == p, {req, " R2 tick spacing"}, secondTick - firstTick, p);
    check(ticksSeen == 2, {req, " R2 single-cycle ticks"}, ticksSeen, 2);
    check(firstPre == (1 << k) - 1, {req, " R3 first preTick"}, firstPre, (1 << k) - 1);
    check(preCount == 2 * n, {req, " R3 preTicks per period"}, preCount, 2 * n);
  endtask

  task automatic writeRegs(bit ws, int s, bit wc, int c);
    @(negedge clk);
    selWrite = ws; selData = 4'(s);
    cntWrite = wc; cntData = 8'(c);
    if (ws) curSel = s;
    if (wc) curCnt = c;
    @(negedge clk);
    selWrite = 1'b0;
    cntWrite = 1'b0;
  endtask

  initial begin
    int quietBad;
    void'($urandom(32'h1234_5EED));
    clkEn = 1'b1;
    repeat (3) @(negedge clk);
    #5;
    check(!tick && !preTick, "R1 outputs low in reset", int'(tick) + int'(preTick), 0);
    @(negedge clk);
    rstN = 1'b1;
    observe("R1 reset config");

    writeRegs(1, 3, 1, 20);
    observe("R7 both written");

    writeRegs(1, 0, 1, 3);
    observe("R5 R6 clamped low");

    writeRegs(1, 15, 1, 8);
    observe("R4 clamped high");

    writeRegs(1, 2, 0, 0);
    observe("R7 count retained");

    writeRegs(0, 0, 1, 50);
    observe("R7 select retained");

    // R8: disabled channel, writes still accepted
    @(negedge clk);
    clkEn = 1'b0;
    quietBad = 0;
    for (int i = 0; i < 100; i++) begin
      #5;
      if (tick || preTick) quietBad++;
      @(negedge clk);
    end
    check(quietBad == 0, "R8 quiet while disabled", quietBad, 0);
    writeRegs(1, 1, 1, 9);
    clkEn = 1'b1;
    observe("R8 restart on enable");

    // R7: random configurations rewritten mid-count
    for (int r = 0; r < 6; r++) begin
      int s1 = $urandom_range(0, 3);
      int c1 = $urandom_range(0, 255);
      writeRegs(1, s1, 1, c1);
      repeat ($urandom_range(3, 40)) @(negedge clk);
      writeRegs(1, $urandom_range(0, 3), 1, $urandom_range(0, 255));
      observe("R7 mid-count restart");
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 190000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule